// File: doc/BRIEF.md
# Register-Triggered Serial EEPROM Word Reader

This block lets software fetch a single 16-bit word from a serial EEPROM on a four-wire link (select, clock, data out, data in) by writing one 32-bit register. The write carries the word address in bits 15:2 and a start flag in bit 0. The block then runs one read transaction on the serial pins. When the transaction finishes, it puts the fetched word in bits 31:16 of the same register and sets a completion flag in bit 1. Software polls the register until that flag reads 1.

The serial transaction has three parts, all sent or received MSB first. A fixed read opcode goes out first, then the word address zero-extended to the serial address width. The EEPROM then returns its data bits, and the block samples each one on a rising serial-clock edge. The serial clock is the system clock divided by a parameter. The fetched word is delivered only through the read register and never reaches any configuration state.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset the register reads all zeros, and the select, serial clock and data-out pins are all low.
- R2: A register write with bit 0 set while the block is idle starts a read. On the next cycle the register shows the written address in bits 15:2, with bit 1 and bits 31:16 cleared.
- R3: The serial command is the opcode (default 3'b110, OP_W bits) followed by the register address zero-extended to 16 bits, both MSB first. The data-out pin is stable at each rising serial-clock edge that carries a bit.
- R4: After the command, 16 data bits are sampled from the data-in pin on the next 16 rising serial-clock edges, MSB first. They appear in register bits 31:16.
- R5: Bit 1 (done) rises in the same cycle that the select pin falls, and the data field is valid from that cycle on. Done stays 0 while select is high.
- R6: Select (active high) stays high for the whole transaction, which is exactly OP_W+32 rising serial-clock edges.
- R7: The serial clock is low while idle. Its period is 2*CLK_DIV system clock cycles.
- R8: A register write with bit 0 clear has no effect on the register contents or on the serial pins.
- R9: A write with bit 0 set while a transaction is running is ignored: the address field and the running transaction are unchanged.
- R10: Register bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the read register |
| reg_wdata | input | 32 | Write data: bit 0 start, bits 15:2 address |
| reg_rdata | output | 32 | Register value: bits 31:16 data, 15:2 address, bit 1 done |
| ser_cs | output | 1 | EEPROM select, active high |
| ser_sck | output | 1 | Serial clock |
| ser_mosi | output | 1 | Serial data to the EEPROM |
| ser_miso | input | 1 | Serial data from the EEPROM |

## Verification
A wrong bit counter or a wrong shift-register state shows up at the pins within one transaction. It appears as a select window with the wrong number of clock edges, or as a misordered command captured by the EEPROM model. Any such fault also corrupts the data field the moment done rises. A divider fault shows up between the first two rising serial-clock edges as a wrong period. A fault in the register state shows up on the cycle after a write: the address field changes when it should hold, or done and data fail to clear on a new start.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
   localparam int REG_W       = 32;
   localparam int START_BIT   = 0;
   localparam int DONE_BIT    = 1;
   localparam int ADDR_LSB    = 2;
   localparam int ADDR_FLD_W  = 14;
   localparam int DATA_LSB    = 16;
   localparam int DATA_W      = 16;

   typedef enum logic [0:0] {
      ENG_IDLE  = 1'b0,
      ENG_SHIFT = 1'b1
   } eng_state_t;
endpackage

// File: rtl/ewr_tickgen.sv
module ewr_tickgen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("ewr_tickgen: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         assign tick = en && (cnt_q == CW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!en || tick) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ewr_engine.sv
module ewr_engine
   import ewr_pkg::*;
#(
   parameter int              OP_W    = 3,
   parameter logic [OP_W-1:0] OP_CODE = 3'b110,
   parameter int              ADDR_W  = 16,
   parameter int              WORD_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              tick,
   output logic              busy,
   output logic              fin,
   output logic [WORD_W-1:0] rx_word,
   output logic              cs,
   output logic              sck,
   output logic              mosi,
   input  logic              miso
);
   localparam int CMD_W = OP_W + ADDR_W;
   localparam int TOT   = CMD_W + WORD_W;
   localparam int CNT_W = $clog2(TOT + 1);

   generate
      if (OP_W < 1 || WORD_W < 2) begin : g_bad_widths
         $error("ewr_engine: OP_W must be >= 1 and WORD_W >= 2");
      end
   endgenerate

   eng_state_t        state_q;
   logic [CNT_W-1:0]  bit_idx_q;
   logic [CMD_W-1:0]  tx_sr_q;
   logic [WORD_W-1:0] rx_sr_q;
   logic              cs_q;
   logic              sck_q;
   logic              last_bit;
   logic              in_data_phase;

   assign last_bit      = (bit_idx_q == CNT_W'(TOT - 1));
   assign in_data_phase = (bit_idx_q >= CNT_W'(CMD_W));
   assign busy          = (state_q == ENG_SHIFT);
   assign fin           = busy && tick && sck_q && last_bit;
   assign rx_word       = rx_sr_q;
   assign cs            = cs_q;
   assign sck           = sck_q;
   assign mosi          = cs_q & tx_sr_q[CMD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ENG_IDLE;
         bit_idx_q <= '0;
         tx_sr_q   <= '0;
         rx_sr_q   <= '0;
         cs_q      <= 1'b0;
         sck_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ENG_IDLE: begin
               if (start) begin
                  state_q   <= ENG_SHIFT;
                  cs_q      <= 1'b1;
                  sck_q     <= 1'b0;
                  bit_idx_q <= '0;
                  tx_sr_q   <= {OP_CODE, start_addr};
                  rx_sr_q   <= '0;
               end
            end
            ENG_SHIFT: begin
               if (tick) begin
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                     if (in_data_phase) begin
                        rx_sr_q <= {rx_sr_q[WORD_W-2:0], miso};
                     end
                  end else begin
                     sck_q <= 1'b0;
                     if (last_bit) begin
                        state_q <= ENG_IDLE;
                        cs_q    <= 1'b0;
                     end else begin
                        bit_idx_q <= bit_idx_q + 1'b1;
                        tx_sr_q   <= {tx_sr_q[CMD_W-2:0], 1'b0};
                     end
                  end
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   // R7: serial clock rests low outside a transaction
   p_sck_low_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck_q);
   // R7: serial clock only moves on a divider tick
   p_sck_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sck_q) |-> $past(tick));
   // R6: select drops right after the final bit
   p_cs_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !cs_q);
   // R6: select high whenever a transaction is running
   p_cs_covers_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cs_q);
endmodule

// File: rtl/ewr_regif.sv
module ewr_regif
   import ewr_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_W-1:0]      wdata,
   input  logic                  busy,
   input  logic                  fin,
   input  logic [DATA_W-1:0]     rx_word,
   output logic                  start,
   output logic [ADDR_FLD_W-1:0] start_addr,
   output logic [REG_W-1:0]      rdata
);
   logic [ADDR_FLD_W-1:0] addr_q;
   logic [DATA_W-1:0]     data_q;
   logic                  done_q;

   assign start      = wr_en && wdata[START_BIT] && !busy;
   assign start_addr = wdata[ADDR_LSB +: ADDR_FLD_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         done_q <= 1'b0;
      end else if (start) begin
         addr_q <= start_addr;
         data_q <= '0;
         done_q <= 1'b0;
      end else if (fin) begin
         data_q <= rx_word;
         done_q <= 1'b1;
      end
   end

   always_comb begin
      rdata                           = '0;
      rdata[DATA_LSB +: DATA_W]       = data_q;
      rdata[ADDR_LSB +: ADDR_FLD_W]   = addr_q;
      rdata[DONE_BIT]                 = done_q;
   end

   // R2: an accepted start clears done and the data field
   p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done_q && data_q == '0));
   // R9: start while busy leaves the address field alone
   p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[START_BIT] && busy && !fin) |=> $stable(addr_q));
   // R8: writes without the start flag change nothing
   p_noop_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wdata[START_BIT] && !fin) |=> ($stable(addr_q) && $stable(done_q)));
   // R5: done only rises at the end of a transaction
   p_done_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(fin));
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
   import ewr_pkg::*;
#(
   parameter int              CLK_DIV    = 4,
   parameter int              OP_W       = 3,
   parameter logic [OP_W-1:0] OP_CODE    = 3'b110,
   parameter int              SER_ADDR_W = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_en,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        ser_cs,
   output logic        ser_sck,
   output logic        ser_mosi,
   input  logic        ser_miso
);
   generate
      if (SER_ADDR_W < ADDR_FLD_W) begin : g_bad_addr
         $error("eeprom_word_reader: SER_ADDR_W must cover the address field");
      end
   endgenerate

   logic                  start;
   logic [ADDR_FLD_W-1:0] fld_addr;
   logic [SER_ADDR_W-1:0] ser_addr;
   logic                  busy;
   logic                  fin;
   logic                  tick;
   logic [DATA_W-1:0]     rx_word;

   assign ser_addr = SER_ADDR_W'(fld_addr);

   ewr_regif i_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wdata     (reg_wdata),
      .busy      (busy),
      .fin       (fin),
      .rx_word   (rx_word),
      .start     (start),
      .start_addr(fld_addr),
      .rdata     (reg_rdata)
   );

   ewr_tickgen #(.DIV(CLK_DIV)) i_tickgen (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (busy),
      .tick (tick)
   );

   ewr_engine #(
      .OP_W   (OP_W),
      .OP_CODE(OP_CODE),
      .ADDR_W (SER_ADDR_W),
      .WORD_W (DATA_W)
   ) i_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_addr(ser_addr),
      .tick      (tick),
      .busy      (busy),
      .fin       (fin),
      .rx_word   (rx_word),
      .cs        (ser_cs),
      .sck       (ser_sck),
      .mosi      (ser_mosi),
      .miso      (ser_miso)
   );

   // R10: the start flag never reads back
   p_start_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[START_BIT] == 1'b0);
   // R5: done is never seen while the select pin is high
   p_done_excl_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ser_cs |-> !reg_rdata[DONE_BIT]);
endmodule

// File: tb/test_eeprom_word_reader.sv
module test_eeprom_word_reader;
   localparam int  CLK_PERIOD = 10;
   localparam int  DIV        = 2;
   localparam int  OPW        = 3;
   localparam logic [2:0] OPC = 3'b110;
   localparam int  EDGES      = OPW + 32;
   localparam int  CMDN       = OPW + 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ser_cs, ser_sck, ser_mosi;
   logic        ser_miso = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_word_reader #(.CLK_DIV(DIV), .OP_W(OPW), .OP_CODE(OPC)) i_eeprom_word_reader (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .ser_cs(ser_cs), .ser_sck(ser_sck),
      .ser_mosi(ser_mosi), .ser_miso(ser_miso)
   );

   function automatic logic [15:0] mem_word(input logic [15:0] a);
      return 16'(a * 16'h9E37) ^ {a[7:0], a[15:8]} ^ 16'h5A5A;
   endfunction

   // EEPROM model
   int              edge_cnt = 0;
   logic [CMDN-1:0] cmd_sr = '0;
   realtime         t_prev = 0, t_last = 0;

   always @(posedge ser_cs) edge_cnt = 0;
   always @(posedge ser_sck) begin
      if (ser_cs) begin
         edge_cnt = edge_cnt + 1;
         t_prev = t_last;
         t_last = $realtime;
         if (edge_cnt <= CMDN) cmd_sr = {cmd_sr[CMDN-2:0], ser_mosi};
      end
   end
   always @(negedge ser_sck) begin
      if (ser_cs && edge_cnt >= CMDN && edge_cnt < EDGES) begin
         ser_miso = mem_word(cmd_sr[15:0])[EDGES - 1 - edge_cnt];
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [31:0] v);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr_en = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic do_read(input logic [13:0] a, input bit poke);
      logic [15:0] exp_w;
      int          guard;
      exp_w = mem_word({2'b00, a});
      reg_write({16'h0, a, 2'b01});
      chk(reg_rdata[15:2] == a, "R2 addr field", {18'h0, reg_rdata[15:2]}, {18'h0, a});
      chk(reg_rdata[1] == 1'b0 && reg_rdata[31:16] == 16'h0, "R2 clear",
          reg_rdata, {16'h0, a, 2'b00});
      chk(ser_cs == 1'b1, "R6 cs active", {31'h0, ser_cs}, 32'h1);
      if (poke) begin
         repeat (5) @(negedge clk);
         reg_write({16'hFFFF, ~a, 2'b01});
         chk(reg_rdata[15:2] == a, "R9 busy start ignored",
             {18'h0, reg_rdata[15:2]}, {18'h0, a});
         reg_write({16'hFFFF, ~a, 2'b10});
         chk(reg_rdata[15:2] == a && reg_rdata[1] == 1'b0, "R8 write no start busy",
             reg_rdata, {16'h0, a, 2'b00});
      end
      guard = 0;
      while (!reg_rdata[1] && guard < 2000) begin
         @(negedge clk);
         if (ser_cs && reg_rdata[1]) chk(1'b0, "R5 done with cs", 32'h1, 32'h0);
         guard++;
      end
      chk(reg_rdata[1] == 1'b1, "R5 done set", {31'h0, reg_rdata[1]}, 32'h1);
      chk(ser_cs == 1'b0, "R5 cs low with done", {31'h0, ser_cs}, 32'h0);
      chk(reg_rdata[31:16] == exp_w, "R4 data", {16'h0, reg_rdata[31:16]}, {16'h0, exp_w});
      chk(edge_cnt == EDGES, "R6 edge count", edge_cnt, EDGES);
      chk(cmd_sr == {OPC, 2'b00, a}, "R3 command", 32'(cmd_sr), 32'({OPC, 2'b00, a}));
      chk(int'((t_last - t_prev) / CLK_PERIOD) == 2 * DIV, "R7 sck period",
          int'((t_last - t_prev) / CLK_PERIOD), 2 * DIV);
      chk(reg_rdata[0] == 1'b0, "R10 bit0", {31'h0, reg_rdata[0]}, 32'h0);
      chk(ser_sck == 1'b0, "R7 sck idle low", {31'h0, ser_sck}, 32'h0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] snap;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(reg_rdata == 32'h0, "R1 reset reg", reg_rdata, 32'h0);
      chk({ser_cs, ser_sck, ser_mosi} == 3'b000, "R1 reset pins",
          {29'h0, ser_cs, ser_sck, ser_mosi}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      do_read(14'h0000, 1'b0);
      do_read(14'h3FFF, 1'b1);
      do_read(14'h2AAA, 1'b0);

      // R8: idle write without start flag changes nothing
      snap = reg_rdata;
      reg_write({16'h1234, 14'h0155, 2'b10});
      repeat (3 * DIV) @(negedge clk);
      chk(reg_rdata == snap, "R8 idle noop reg", reg_rdata, snap);
      chk(ser_cs == 1'b0 && ser_sck == 1'b0, "R8 idle noop pins",
          {30'h0, ser_cs, ser_sck}, 32'h0);

      for (int i = 0; i < 25; i++) begin
         do_read(14'($urandom), 1'($urandom));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule